// File: doc/BRIEF.md
# Serial Switch-Status Reporter with Change Interrupt

This block is a serial-peripheral slave that lets a host microcontroller read the state of 22 already-debounced switch inputs. In the same exchange the host loads a 24-bit command word. The host pulls chip select low. The block then freezes the switch states into a status word and enables its serial-out driver. Over 24 clock pulses it shifts that status word out and shifts the command in. Both directions run most significant bit first. When chip select returns high, the driver is released and a complete command word is committed to the configuration output.

An active-low interrupt tells the host that a switch differs from the last state it was given. The interrupt is held for the whole of a transaction. It is released when chip select rises, unless a switch moved while the transaction was in progress.

The serial pins are oversampled by a faster system clock. Each pin passes through a synchroniser, and its edges are detected in the system-clock domain. The block assumes an idle-low serial clock: the serial clock must be low whenever chip select changes level.

Top module: `swstat_spi_slave`

## Requirements
- R1: After reset `int_n` is 1, `cfg` is all zeros and `so_oe` is 0.
- R2: The status word holds switch `k` in bit `k` for k = 0..21, with closed switches reading 1 and open switches reading 0. Bits 23 and 22 always read 0.
- R3: The first serial-clock rising edge of a transaction puts status bit 23 on `so`. Each later rising edge puts the next lower bit there, so the host reads all 24 bits most significant first.
- R4: The status word reflects the switch inputs at the chip-select falling edge. Switch changes during the transaction do not alter it.
- R5: `so_oe` goes to 1 after the chip-select falling edge and back to 0 after the rising edge. It is 0 whenever chip select is high.
- R6: `si` is captured on each serial-clock falling edge. After exactly 24 falling edges, the chip-select rising edge loads the word into `cfg`, with the first bit received landing in `cfg[23]`.
- R7: While chip select is high, activity on `sclk` and `si` leaves `cfg` and `so_oe` unchanged.
- R8: If chip select rises after a number of falling edges other than 24 (fewer or more, including none), `cfg` keeps its previous value.
- R9: While chip select is high, any difference between the switch inputs and the last reported status drives `int_n` to 0.
- R10: An asserted `int_n` stays 0 for the whole transaction. If no switch changed during the transaction, `int_n` returns to 1 after chip select rises.
- R11: If any switch changed while chip select was low, `int_n` remains 0 after chip select rises. This holds even if the switch returned to its earlier value before the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial status data to host |
| so_oe | output | 1 | Driver enable for `so`; 0 means high impedance |
| sw_in | input | 22 | Debounced switch states, 1 = closed |
| cfg | output | 24 | Last fully received command word |
| int_n | output | 1 | Active-low switch-change interrupt |

## Verification
Two functions can fall due in the same window. The chip-select rising edge releases the interrupt, while the change detector may have seen a switch move during that same transaction. The bench provokes this by changing `sw_in` midway through the shift. In one case the switch is changed once; in the other it is changed and then restored. In both cases `int_n` must stay low after the transaction, and the status read back must still be the state frozen at the falling edge. The opposite case, a transaction with no switch movement, must release the interrupt. Repeated sweeps of walking-one and dense switch patterns, each with a distinct command, judge status ordering and command commit together.

// File: rtl/swstat_pkg.sv
package swstat_pkg;

  // Counter width able to hold 0 .. w+1 (w+1 marks an over-long word).
  function automatic int unsigned cnt_width(input int unsigned w);
    return $clog2(w + 2);
  endfunction

  // Serial-pin positions inside the synchroniser vector.
  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCLK = 1;
  localparam int unsigned PIN_SI   = 2;
  localparam int unsigned PIN_N    = 3;

endpackage

// File: rtl/swstat_sync.sv
module swstat_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] pipe [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~prev;
  assign fall  = ~pipe[STAGES-1] & prev;

endmodule

// File: rtl/swstat_shift.sv
module swstat_shift
  import swstat_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned CW = cnt_width(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_out,
  input  logic              shift_in,
  input  logic              si_bit,
  output logic              so_bit,
  output logic [WORD_W-1:0] rx_word,
  output logic [CW-1:0]     bit_cnt,
  output logic              word_full
);

  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
  localparam logic [CW-1:0] CNT_OVER = CW'(WORD_W + 1);

  logic [WORD_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_word <= '0;
      bit_cnt <= '0;
      so_bit  <= 1'b0;
    end else if (load) begin
      tx_q    <= load_word;
      bit_cnt <= '0;
      so_bit  <= 1'b0;
    end else begin
      if (shift_out) begin
        so_bit <= tx_q[WORD_W-1];
        tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
      end
      if (shift_in) begin
        rx_word <= {rx_word[WORD_W-2:0], si_bit};
        if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign word_full = (bit_cnt == CNT_FULL);

endmodule

// File: rtl/swstat_irq.sv
module swstat_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_diff,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic active,
  output logic int_n
);

  logic irq_q;
  logic moved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      moved_q <= 1'b0;
    end else if (cs_rise) begin
      irq_q   <= moved_q | sw_diff;
      moved_q <= 1'b0;
    end else if (cs_fall) begin
      irq_q   <= irq_q | sw_diff;
      moved_q <= 1'b0;
    end else if (active) begin
      moved_q <= moved_q | sw_diff;
    end else begin
      irq_q <= irq_q | sw_diff;
    end
  end

  assign int_n = ~irq_q;

endmodule

// File: rtl/swstat_spi_slave.sv
module swstat_spi_slave
  import swstat_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned SW_N        = 22,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = cnt_width(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic [SW_N-1:0]   sw_in,
  output logic [WORD_W-1:0] cfg,
  output logic              int_n
);

  function automatic logic [WORD_W-1:0] pack_status(input logic [SW_N-1:0] s);
    return WORD_W'(s);
  endfunction

  logic [PIN_N-1:0] pin_lvl, pin_rise, pin_fall;
  logic             sync_unused;

  swstat_sync #(
    .N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_N'(1) << PIN_CS)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .din({si, sclk, cs_n}),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign sync_unused = &{pin_rise[PIN_SI], pin_fall[PIN_SI], pin_lvl[PIN_SCLK]};

  // Named internal events
  logic active, cs_fall_evt, cs_rise_evt, sclk_rise_evt, sclk_fall_evt;
  assign active        = ~pin_lvl[PIN_CS];
  assign cs_fall_evt   = pin_fall[PIN_CS];
  assign cs_rise_evt   = pin_rise[PIN_CS];
  assign sclk_rise_evt = pin_rise[PIN_SCLK] & active;
  assign sclk_fall_evt = pin_fall[PIN_SCLK] & active;

  logic [WORD_W-1:0] snap;
  logic [WORD_W-1:0] rx_word;
  logic [CW-1:0]     bit_cnt;
  logic              word_full;
  logic              sw_diff;

  swstat_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(cs_fall_evt), .load_word(pack_status(sw_in)),
    .shift_out(sclk_rise_evt), .shift_in(sclk_fall_evt),
    .si_bit(pin_lvl[PIN_SI]), .so_bit(so),
    .rx_word(rx_word), .bit_cnt(bit_cnt), .word_full(word_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap  <= '0;
      cfg   <= '0;
      so_oe <= 1'b0;
    end else begin
      if (cs_fall_evt) begin
        snap  <= pack_status(sw_in);
        so_oe <= 1'b1;
      end
      if (cs_rise_evt) begin
        so_oe <= 1'b0;
        if (word_full) cfg <= rx_word;
      end
    end
  end

  assign sw_diff = (sw_in != snap[SW_N-1:0]);

  swstat_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sw_diff(sw_diff),
    .cs_fall(cs_fall_evt), .cs_rise(cs_rise_evt), .active(active),
    .int_n(int_n)
  );

endmodule

// File: rtl/swstat_spi_slave_chk.sv
module swstat_spi_slave_chk #(
  parameter int unsigned WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic              cs_fall_evt,
  input logic              cs_rise_evt,
  input logic              sclk_rise_evt,
  input logic              word_full,
  input logic              so,
  input logic              so_oe,
  input logic [WORD_W-1:0] cfg,
  input logic [WORD_W-1:0] snap,
  input logic              int_n
);

  a_r3_so_moves_on_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise_evt && !cs_fall_evt) |=> $stable(so));

  a_r4_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall_evt |=> $stable(snap));

  a_r5_oe_on_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_evt |=> so_oe);

  a_r5_oe_off_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_evt |=> !so_oe);

  a_r7_cfg_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_rise_evt && word_full) |=> $stable(cfg));

  a_r8_partial_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_evt && !word_full) |=> $stable(cfg));

  a_r10_int_held_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cs_rise_evt && !int_n) |=> !int_n);

endmodule

bind swstat_spi_slave swstat_spi_slave_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active),
  .cs_fall_evt(cs_fall_evt), .cs_rise_evt(cs_rise_evt),
  .sclk_rise_evt(sclk_rise_evt), .word_full(word_full),
  .so(so), .so_oe(so_oe), .cfg(cfg), .snap(snap), .int_n(int_n)
);

// File: tb/swstat_spi_slave_bench.sv
module swstat_spi_slave_bench;

  localparam int W  = 24;
  localparam int SN = 22;
  localparam int GAP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [SN-1:0] sw_in = '0;
  logic          so, so_oe, int_n;
  logic [W-1:0]  cfg;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  swstat_spi_slave u_swstat_spi_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
    .so(so), .so_oe(so_oe), .sw_in(sw_in), .cfg(cfg), .int_n(int_n)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pause();
    repeat (GAP) @(negedge clk);
  endtask

  // Host-side transaction: nbits clocks, optional switch changes at two bit positions.
  task automatic xfer(input logic [W-1:0] cmd, input int nbits,
                      input int c1, input logic [SN-1:0] v1,
                      input int c2, input logic [SN-1:0] v2,
                      output logic [W-1:0] stat);
    stat = '0;
    cs_n = 1'b0;
    pause();
    check("R5 oe after cs fall", W'(so_oe), W'(1));
    for (int i = 0; i < nbits; i++) begin
      si = (i < W) ? cmd[W-1-i] : 1'b0;
      if (i == c1) sw_in = v1;
      if (i == c2) sw_in = v2;
      pause();
      sclk = 1'b1;
      pause();
      if (i < W) stat[W-1-i] = so;
      sclk = 1'b0;
      pause();
    end
    cs_n = 1'b1;
    pause();
    check("R5 oe after cs rise", W'(so_oe), W'(0));
  endtask

  function automatic logic [W-1:0] mk_cmd(input int k);
    return W'(k * 24'h05A5A3 + 24'h123457) ^ (W'(1) << (k % W));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] st;
    logic [W-1:0] cfg_prev;
    logic [SN-1:0] pat [4];
    pat[0] = '1; pat[1] = 22'h2AAAAA; pat[2] = 22'h155555; pat[3] = '0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    pause();
    // R1
    check("R1 int_n reset", W'(int_n), W'(1));
    check("R1 cfg reset", cfg, '0);
    check("R1 so_oe reset", W'(so_oe), W'(0));

    // R2 R3 R6 R9 R10: walking-one sweep
    for (int k = 0; k < SN; k++) begin
      sw_in = SN'(1) << k;
      pause();
      check("R9 change raises int", W'(int_n), W'(0));
      xfer(mk_cmd(k), W, -1, '0, -1, '0, st);
      check("R2 R3 status walking one", st, W'(SN'(1) << k));
      check("R6 command commit", cfg, mk_cmd(k));
      check("R10 release after quiet xfer", W'(int_n), W'(1));
    end

    // R2 dense patterns, top bits zero
    for (int p = 0; p < 4; p++) begin
      sw_in = pat[p];
      pause();
      xfer(~mk_cmd(p + 40), W, -1, '0, -1, '0, st);
      check("R2 status pattern", st, {2'b00, pat[p]});
      check("R2 top bits zero", W'(st[W-1:SN]), '0);
      check("R6 command commit pattern", cfg, ~mk_cmd(p + 40));
    end

    // R7: clocks and data while deselected
    cfg_prev = cfg;
    si = 1'b1;
    for (int i = 0; i < W; i++) begin
      sclk = 1'b1; pause(); sclk = 1'b0; pause();
    end
    si = 1'b0;
    check("R7 cfg after idle clocks", cfg, cfg_prev);
    check("R7 oe after idle clocks", W'(so_oe), W'(0));

    // R8: wrong lengths
    xfer(24'hF0F0F0, W - 1, -1, '0, -1, '0, st);
    check("R8 short word", cfg, cfg_prev);
    xfer(24'h0F0F0F, W + 1, -1, '0, -1, '0, st);
    check("R8 long word", cfg, cfg_prev);
    xfer(24'h777777, 0, -1, '0, -1, '0, st);
    check("R8 empty select", cfg, cfg_prev);
    xfer(24'hC3A55A, W, -1, '0, -1, '0, st);
    check("R6 commit after discards", cfg, 24'hC3A55A);

    // R10: interrupt held during transaction
    sw_in = 22'h00F00F;
    pause();
    check("R9 int before xfer", W'(int_n), W'(0));
    cs_n = 1'b0;
    pause();
    check("R10 int held in xfer", W'(int_n), W'(0));
    cs_n = 1'b1;
    pause();
    check("R10 int released", W'(int_n), W'(1));

    // R4 R11: switch change during transaction
    sw_in = 22'h0000AA;
    pause();
    xfer(24'h111111, W, 10, 22'h3000AA, -1, '0, st);
    check("R4 status frozen at cs fall", st, W'(22'h0000AA));
    check("R11 int kept after change in xfer", W'(int_n), W'(0));
    xfer(24'h222222, W, -1, '0, -1, '0, st);
    check("R4 next status sees change", st, W'(22'h3000AA));
    check("R10 int released next xfer", W'(int_n), W'(1));

    // R11: change then revert inside one transaction
    xfer(24'h333333, W, 5, 22'h3000AB, 15, 22'h3000AA, st);
    check("R4 status before revert", st, W'(22'h3000AA));
    check("R11 int kept after revert", W'(int_n), W'(0));
    xfer(24'h444444, W, -1, '0, -1, '0, st);
    check("R10 int released after revert xfer", W'(int_n), W'(1));
    check("R6 last command", cfg, 24'h444444);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule